// File: doc/BRIEF.md
# LED Matrix Bit-Plane Stream Scanner

The scanner turns a continuous stream of 32-bit words into the control waveforms of a multiplexed LED matrix. Each word is split into four bytes, lowest byte first, and the bytes are read as fixed 60-byte records. One record carries one bit-plane of one display row: a pixel count, the colour bits for that row, a row address and a 24-bit on-time. The scanner clocks the colour bits serially into the column driver chain, places the row address on the row-select lines, pulses the latch, and then lets the LEDs light for exactly the number of clock cycles given in the record. Every record describes itself, so the block keeps no frame, plane or row counters of its own. Whatever produces the stream decides the order of planes and rows and the plane weighting.

The control path is one state machine with eight states. SC_HEAD reads the count byte. SC_BODY walks byte positions 1 to 55 and either keeps or drops each byte. SC_SHIFT_LO and SC_SHIFT_HI give each colour bit a clock-low half and a clock-high half. SC_ROW takes the row byte. SC_TIME gathers the three on-time bytes. SC_LATCH gives the one-cycle latch pulse. SC_ON is the lit interval.

The transitions are as follows:
- SC_HEAD to SC_BODY: a byte is taken.
- SC_BODY to SC_SHIFT_LO: the byte taken is a live pixel.
- SC_BODY to SC_ROW: the byte taken is at position 55.
- SC_SHIFT_LO to SC_SHIFT_HI: always.
- SC_SHIFT_HI to SC_SHIFT_LO: more bits of the pixel remain.
- SC_SHIFT_HI to SC_BODY: the third bit of the pixel is done.
- SC_ROW to SC_TIME: a byte is taken.
- SC_TIME to SC_LATCH: the last on-time byte is taken.
- SC_LATCH to SC_ON: the on-time is not zero.
- SC_LATCH to SC_HEAD: the on-time is zero.
- SC_ON to SC_HEAD: the on-time counter reaches its last cycle.

Any state that needs a byte waits in place while no byte is available.

Top module: `bps_scanner`

## Requirements
- R1: While reset is held and after it is released with no input, `col_blank` is 1, `col_clk` is 0, `col_latch` is 0, `row_sel` is 0 and `in_ready` is 1.
- R2: Each accepted word yields four bytes in the order bits [7:0], [15:8], [23:16] and [31:24].
- R3: Record byte 0 holds the pixel count minus one. The scanner takes the next min(count+1, 53) bytes at positions 1 to 53 as pixels, and each pixel gives exactly three rising edges of `col_clk`.
- R4: The colour bits of a pixel leave on `col_data` in this order: bit 0 (red), then bit 1 (green), then bit 2 (blue). `col_data` is stable across every rising edge of `col_clk`. Bits 7 to 3 of a pixel byte have no effect.
- R5: Pixel slots beyond the count, and padding bytes 54 and 55, are consumed without any `col_clk` edge.
- R6: The low 4 bits of record byte 56 appear on `row_sel`. `row_sel` only changes while `col_blank` is 1 and was 1 in the cycle before.
- R7: Bytes 57, 58 and 59 form a 24-bit on-time, least significant byte first. After the latch, `col_blank` is 0 for exactly that many cycles. An on-time of 0 leaves the outputs blanked.
- R8: `col_latch` pulses for one cycle per record. The pulse comes after the row address is set and before the lit interval, with `col_blank` at 1 and `col_clk` at 0.
- R9: When input words stop arriving in the middle of a record, the scanner holds `col_blank` at 1 and makes no `col_clk` edges. When words resume, it continues with no byte lost.
- R10: Records follow one another with no separator. After each record's lit interval (or its latch, when the on-time is 0), the next byte is read as the count byte of a new record.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Input word, lowest byte consumed first |
| in_ready | output | 1 | Scanner accepts the word this cycle |
| col_clk | output | 1 | Column shift clock |
| col_data | output | 1 | Serial colour bit for the column chain |
| col_latch | output | 1 | Column register latch pulse |
| col_blank | output | 1 | Output blanking, 1 turns the LEDs off |
| row_sel | output | 4 | Row address |

## Verification
The checker watches three properties on every cycle. It checks that the row lines move only inside a blanked stretch. It checks that the latch is a single-cycle pulse that never coincides with a column clock or a lit output. It checks that serial data is held steady through each rising clock edge and that no column clock appears while the LEDs are lit.

Some behaviours cannot be written as properties on every cycle. Only the bench scenarios show the exact number of shifted bits for each pixel count, the colour bit order, the dropping of padding and unused slots, the multi-byte on-time length, and the zero on-time case. The same holds for the clean resumption after an input stall in the middle of a record.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam int BYTE_W      = 8;
    localparam int REC_BYTES   = 60;
    localparam int TICK_BYTES  = 3;
    localparam int TICK_W      = TICK_BYTES * BYTE_W;
    localparam int COLOR_BITS  = 3;
    // Record positions: row byte sits just before the on-time bytes, two
    // padding bytes sit before the row byte.
    localparam int ROW_POS     = REC_BYTES - 1 - TICK_BYTES;
    localparam int LAST_PAD    = ROW_POS - 1;
    localparam int PIX_LAST    = ROW_POS - 3;
    localparam int IDX_W       = $clog2(REC_BYTES);
    localparam int TB_W        = $clog2(TICK_BYTES);
    localparam int CB_W        = $clog2(COLOR_BITS);

    typedef enum logic [2:0] {
        SC_HEAD,
        SC_BODY,
        SC_SHIFT_LO,
        SC_SHIFT_HI,
        SC_ROW,
        SC_TIME,
        SC_LATCH,
        SC_ON
    } scan_state_t;

endpackage

// File: rtl/bps_word_unpack.sv
module bps_word_unpack #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    input  logic              byte_take
);

    localparam int LANES = WORD_W / BYTE_W;
    localparam int CNT_W = $clog2(LANES + 1);

    logic [WORD_W-1:0] word_q;
    logic [CNT_W-1:0]  left_q;

    assign byte_valid = (left_q != '0);
    assign byte_data  = word_q[BYTE_W-1:0];
    // Refill as the last lane is consumed, so a steady stream has no bubble.
    assign in_ready   = (left_q == '0) || ((left_q == CNT_W'(1)) && byte_take);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
        end else if (in_valid && in_ready) begin
            word_q <= in_data;
            left_q <= CNT_W'(LANES);
        end else if (byte_take && byte_valid) begin
            word_q <= word_q >> BYTE_W;
            left_q <= left_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/bps_on_timer.sv
module bps_on_timer #(
    parameter int TICK_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TICK_W-1:0] load_val,
    input  logic              run,
    output logic              last
);

    logic [TICK_W-1:0] cnt_q;

    assign last = (cnt_q == TICK_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_q <= cnt_q - TICK_W'(1);
        end
    end

endmodule

// File: rtl/bps_scanner.sv
module bps_scanner
    import bps_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ROW_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              col_clk,
    output logic              col_data,
    output logic              col_latch,
    output logic              col_blank,
    output logic [ROW_W-1:0]  row_sel
);

    scan_state_t state_q, state_d;

    logic              byte_valid;
    logic [BYTE_W-1:0] byte_data;
    logic              byte_take;
    logic              timer_last;

    logic [BYTE_W-1:0]     cnt_q;
    logic [IDX_W-1:0]      idx_q;
    logic [COLOR_BITS-1:0] pix_q;
    logic [CB_W-1:0]       bit_q;
    logic [ROW_W-1:0]      row_q;
    logic [TB_W-1:0]       tb_q;
    logic [TICK_W-1:0]     tick_q;
    logic                  is_pix;

    bps_word_unpack #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_take  (byte_take)
    );

    bps_on_timer #(.TICK_W(TICK_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == SC_LATCH),
        .load_val (tick_q),
        .run      (state_q == SC_ON),
        .last     (timer_last)
    );

    // A body byte is a live pixel when it sits in the pixel area and its
    // slot number does not exceed the count byte.
    assign is_pix = (idx_q <= IDX_W'(PIX_LAST)) &&
                    ((BYTE_W'(idx_q) - BYTE_W'(1)) <= cnt_q);

    assign byte_take = byte_valid &&
                       ((state_q == SC_HEAD) || (state_q == SC_BODY) ||
                        (state_q == SC_ROW)  || (state_q == SC_TIME));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_HEAD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_HEAD: begin
                if (byte_valid) state_d = SC_BODY;
            end
            SC_BODY: begin
                if (byte_valid) begin
                    if (is_pix) begin
                        state_d = SC_SHIFT_LO;
                    end else if (idx_q == IDX_W'(LAST_PAD)) begin
                        state_d = SC_ROW;
                    end
                end
            end
            SC_SHIFT_LO: begin
                state_d = SC_SHIFT_HI;
            end
            SC_SHIFT_HI: begin
                if (bit_q == CB_W'(COLOR_BITS - 1)) state_d = SC_BODY;
                else                                state_d = SC_SHIFT_LO;
            end
            SC_ROW: begin
                if (byte_valid) state_d = SC_TIME;
            end
            SC_TIME: begin
                if (byte_valid && (tb_q == TB_W'(TICK_BYTES - 1))) state_d = SC_LATCH;
            end
            SC_LATCH: begin
                if (tick_q == '0) state_d = SC_HEAD;
                else              state_d = SC_ON;
            end
            SC_ON: begin
                if (timer_last) state_d = SC_HEAD;
            end
            default: state_d = SC_HEAD;
        endcase
    end

    // Record datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            pix_q  <= '0;
            bit_q  <= '0;
            row_q  <= '0;
            tb_q   <= '0;
            tick_q <= '0;
        end else begin
            unique case (state_q)
                SC_HEAD: begin
                    if (byte_valid) begin
                        cnt_q <= byte_data;
                        idx_q <= IDX_W'(1);
                    end
                end
                SC_BODY: begin
                    if (byte_valid) begin
                        idx_q <= idx_q + IDX_W'(1);
                        if (is_pix) begin
                            pix_q <= byte_data[COLOR_BITS-1:0];
                            bit_q <= '0;
                        end
                    end
                end
                SC_SHIFT_LO: begin
                end
                SC_SHIFT_HI: begin
                    pix_q <= pix_q >> 1;
                    bit_q <= bit_q + CB_W'(1);
                end
                SC_ROW: begin
                    if (byte_valid) begin
                        row_q <= byte_data[ROW_W-1:0];
                        tb_q  <= '0;
                    end
                end
                SC_TIME: begin
                    if (byte_valid) begin
                        tick_q[tb_q*BYTE_W +: BYTE_W] <= byte_data;
                        tb_q <= tb_q + TB_W'(1);
                    end
                end
                SC_LATCH: begin
                end
                SC_ON: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        col_clk   = 1'b0;
        col_data  = 1'b0;
        col_latch = 1'b0;
        col_blank = 1'b1;
        unique case (state_q)
            SC_SHIFT_LO: col_data = pix_q[0];
            SC_SHIFT_HI: begin
                col_data = pix_q[0];
                col_clk  = 1'b1;
            end
            SC_LATCH:    col_latch = 1'b1;
            SC_ON:       col_blank = 1'b0;
            default: begin
            end
        endcase
    end

    assign row_sel = row_q;

endmodule

// File: rtl/bps_scan_checks.sv
module bps_scan_checks #(
    parameter int ROW_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             col_clk,
    input logic             col_data,
    input logic             col_latch,
    input logic             col_blank,
    input logic [ROW_W-1:0] row_sel
);

    a_r6_row_moves_blanked: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_sel) |-> (col_blank && $past(col_blank)));

    a_r8_latch_while_dark: assert property (@(posedge clk) disable iff (!rst_n)
        col_latch |-> (col_blank && !col_clk));

    a_r8_latch_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        col_latch |=> !col_latch);

    a_r4_data_held_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_clk) |-> $stable(col_data));

    a_r7_no_shift_when_lit: assert property (@(posedge clk) disable iff (!rst_n)
        !col_blank |-> !col_clk);

endmodule

bind bps_scanner bps_scan_checks #(.ROW_W(ROW_W)) u_scan_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .col_clk   (col_clk),
    .col_data  (col_data),
    .col_latch (col_latch),
    .col_blank (col_blank),
    .row_sel   (row_sel)
);

// File: tb/bps_scanner_tb.sv
module bps_scanner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready, col_clk, col_data, col_latch, col_blank;
    logic [3:0]  row_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    always #4 clk = ~clk;

    bps_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .col_clk(col_clk), .col_data(col_data),
        .col_latch(col_latch), .col_blank(col_blank), .row_sel(row_sel)
    );

    // Fields: row[39:36] count[35:28] tick[27:4] seed[3:1] gap[0]
    localparam logic [39:0] VEC [5] = '{
        {4'd0,  8'd54, 24'd1,   3'd1, 1'b0},
        {4'd0,  8'd2,  24'd2,   3'd5, 1'b1},
        {4'd1,  8'd0,  24'd261, 3'd6, 1'b0},
        {4'd1,  8'd10, 24'd0,   3'd3, 1'b1},
        {4'd15, 8'd52, 24'd8,   3'd0, 1'b0}
    };

    // Monitor state
    int         lat_n = 0;
    int         bits_cur = 0;
    int         ones_cur = 0;
    logic [2:0] first_cur = '0;
    logic       prev_clk = 1'b0;
    int         rec_bits [8];
    int         rec_ones [8];
    int         rec_on   [8];
    logic [3:0] rec_row  [8];
    logic [2:0] rec_first[8];

    initial begin
        for (int i = 0; i < 8; i++) begin
            rec_bits[i] = 0; rec_ones[i] = 0; rec_on[i] = 0;
            rec_row[i] = '0; rec_first[i] = '0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (col_clk && !prev_clk) begin
                if (bits_cur < 3) first_cur[bits_cur] = col_data;
                bits_cur++;
                ones_cur += int'(col_data);
            end
            if (col_latch && lat_n < 8) begin
                rec_bits[lat_n]  = bits_cur;
                rec_ones[lat_n]  = ones_cur;
                rec_row[lat_n]   = row_sel;
                rec_first[lat_n] = first_cur;
                lat_n++;
                bits_cur = 0; ones_cur = 0; first_cur = '0;
            end
            if (!col_blank && lat_n > 0 && lat_n <= 8) rec_on[lat_n-1]++;
            prev_clk = col_clk;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int npix(input logic [7:0] cnt);
        return (int'(cnt) + 1 > 53) ? 53 : int'(cnt) + 1;
    endfunction

    function automatic logic [7:0] rec_byte(input int i, input logic [3:0] row,
                                            input logic [7:0] cnt, input logic [23:0] tick,
                                            input int seed);
        if (i == 0) return cnt;
        if (i <= 53) begin
            if (i - 1 < npix(cnt)) return {5'b10110, 3'((i - 1 + seed) % 8)};
            return 8'hFF;
        end
        if (i == 54 || i == 55) return 8'hFF;
        if (i == 56) return {4'hA, row};
        return tick[(i-57)*8 +: 8];
    endfunction

    function automatic int exp_ones(input logic [7:0] cnt, input int seed);
        int s = 0;
        for (int p = 0; p < npix(cnt); p++) s += $countones(3'((p + seed) % 8));
        return s;
    endfunction

    task automatic send_words(input logic [3:0] row, input logic [7:0] cnt,
                              input logic [23:0] tick, input int seed, input bit gap,
                              input int w_lo, input int w_hi);
        for (int w = w_lo; w <= w_hi; w++) begin
            @(negedge clk);
            in_data  = {rec_byte(4*w+3, row, cnt, tick, seed), rec_byte(4*w+2, row, cnt, tick, seed),
                        rec_byte(4*w+1, row, cnt, tick, seed), rec_byte(4*w,   row, cnt, tick, seed)};
            in_valid = 1'b1;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            #1;
            in_valid = 1'b0;
            if (gap) repeat (5) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            finish_run();
        end
    end

    initial begin
        int snap;
        repeat (4) @(negedge clk);
        // R1: reset state while held
        chk("R1 blank in reset", int'(col_blank), 1);
        chk("R1 clk in reset", int'(col_clk), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: idle after release
        chk("R1 latch idle", int'(col_latch), 0);
        chk("R1 row idle", int'(row_sel), 0);
        chk("R1 ready idle", int'(in_ready), 1);
        chk("R1 blank idle", int'(col_blank), 1);

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R10 (records sent back to back)
        for (int v = 0; v < 5; v++) begin
            send_words(VEC[v][39:36], VEC[v][35:28], VEC[v][27:4], int'(VEC[v][3:1]),
                       VEC[v][0], 0, 14);
        end
        repeat (900) @(negedge clk);
        chk("R8 R10 latch count", lat_n, 5);
        for (int v = 0; v < 5; v++) begin
            chk("R3 R5 shifted bits", rec_bits[v], 3 * npix(VEC[v][35:28]));
            chk("R4 ones on data", rec_ones[v], exp_ones(VEC[v][35:28], int'(VEC[v][3:1])));
            chk("R4 R2 first pixel order", int'(rec_first[v]), int'(VEC[v][3:1]));
            chk("R6 row address", int'(rec_row[v]), int'(VEC[v][39:36]));
            chk("R7 lit cycles", rec_on[v], int'(VEC[v][27:4]));
        end

        // R9: stall after 6 words of a full record
        send_words(4'd9, 8'd54, 24'd3, 2, 1'b0, 0, 5);
        repeat (400) @(negedge clk);
        snap = bits_cur;
        repeat (100) @(negedge clk);
        chk("R9 bits during stall", bits_cur, snap);
        chk("R9 bits before stall", snap, 69);
        chk("R9 blank during stall", int'(col_blank), 1);
        chk("R9 no latch during stall", lat_n, 5);
        send_words(4'd9, 8'd54, 24'd3, 2, 1'b0, 6, 14);
        repeat (600) @(negedge clk);
        chk("R9 resumed bits", rec_bits[5], 159);
        chk("R9 resumed ones", rec_ones[5], exp_ones(8'd54, 2));
        chk("R9 resumed row", int'(rec_row[5]), 9);
        chk("R9 resumed lit cycles", rec_on[5], 3);
        finish_run();
    end

endmodule